// File: doc/BRIEF.md
# Second-Chance List Page Manager

This block tracks which page tags are resident in a fixed pool of frames. It keeps them in two ordered lists. The direct list holds pages that may be touched at full speed; it is a FIFO. The standby list holds pages that are still resident but marked invalid; it is kept in strict least-recently-used order. Membership in the direct list is the read-write marking of a page. Membership in the standby list is its invalid marking.

Every request carries one tag and gets a one-cycle result code. A tag found in the direct list is a hit and changes nothing. Any other tag is a fault. On a fault the oldest direct page drops to the front of the standby list. A tag found in the standby list is then rescued into the front of the direct list. A tag found in neither list is loaded at the front of the direct list. When both lists are already full, the last standby page is evicted and its tag is returned. Moving data to and from backing storage is left to the surrounding system.

Top module: `scl_page_mgr`

## Requirements
- R1: After reset both lists are empty, `rspValid` and `victimValid` are low, and the first request gets code 2.
- R2: Each request sampled at a rising edge produces `rspValid` high for exactly the following cycle, with `rspCode` encoded as 0 = direct hit, 1 = rescue from standby, 2 = fault without eviction, 3 = fault with eviction.
- R3: A request whose tag is in the direct list returns code 0 and changes neither list's contents nor order.
- R4: A missing tag while the direct list is not full is inserted at the direct head with code 2, and no page is demoted.
- R5: On any fault with a full direct list, the direct tail moves to the head of the standby list.
- R6: A tag found in the standby list returns code 1, leaves the standby list, and becomes the head of the direct list.
- R7: A tag in neither list, with both lists full, returns code 3 and evicts the standby tail (the least recently demoted or touched standby page), whose tag appears on `victimTag`.
- R8: A tag in neither list, with the direct list full but the standby list not full, returns code 2 and evicts nothing.
- R9: `victimValid` is high only in a response cycle carrying code 3.
- R10: With a standby capacity `SC_N` of 0 the block is a plain FIFO of `ACT_N` frames, and the victim is the oldest direct page.
- R11: A cycle without a request produces no response and leaves both lists unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | A page access is presented this cycle |
| reqTag | input | TAG_W | Tag of the accessed page |
| rspValid | output | 1 | Result of the previous cycle's access |
| rspCode | output | 2 | Result code, encoding given in R2 |
| victimValid | output | 1 | An eviction happened; `victimTag` is meaningful |
| victimTag | output | TAG_W | Tag of the evicted page |

## Verification
All results, including the code, the victim flag and the victim tag, are registered on the same rising edge that samples the request. They are therefore due exactly one cycle after the stimulus. The bench drives each request on a falling edge and reads the result on the next falling edge. Each comparison therefore looks at the cycle the request's own edge produced. Idle cycles are read in the same way and must show no response. List order is never read directly: it shows up as the codes and victims of later requests, which a bench-side queue model predicts.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [1:0] {
    RSP_HIT    = 2'd0,
    RSP_RESCUE = 2'd1,
    RSP_FILL   = 2'd2,
    RSP_EVICT  = 2'd3
  } rsp_code_e;

  // strobes from control to list datapath
  typedef struct packed {
    logic actInsert;  // place request tag at direct head
    logic demote;     // direct tail leaves the direct list
    logic scRemove;   // remove one standby entry
    logic scRemTail;  // 1: remove standby tail, 0: remove matched entry
    logic scPush;     // demoted tag enters standby head
    logic evict;      // capture victim tag
  } list_ops_t;

endpackage

// File: rtl/scl_lists.sv
module scl_lists
  import scl_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int ACT_N = 3,
  parameter int SC_N  = 2,
  localparam int SC_D = (SC_N > 0) ? SC_N : 1,
  localparam int AIW  = $clog2(ACT_N + 1),
  localparam int SIW  = $clog2(SC_D + 1),
  localparam int SXW  = (SC_D > 1) ? $clog2(SC_D) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TAG_W-1:0] reqTag,
  input  list_ops_t        ops,
  output logic             actHit,
  output logic             scHit,
  output logic             actFull,
  output logic             scFull,
  output logic [AIW-1:0]   actCnt,
  output logic [SIW-1:0]   scCnt,
  output logic [TAG_W-1:0] victimTag
);

  logic [TAG_W-1:0] actQ [ACT_N];
  logic [TAG_W-1:0] scQ  [SC_D];
  logic [TAG_W-1:0] actN [ACT_N];
  logic [TAG_W-1:0] scRem[SC_D];
  logic [TAG_W-1:0] scN  [SC_D];
  logic [AIW-1:0]   actCntN;
  logic [SIW-1:0]   scCntN;
  logic [ACT_N-1:0] actMatch;
  logic [SC_D-1:0]  scMatch;
  logic [SXW-1:0]   scHitIdx;
  logic [SXW-1:0]   remIdx;
  logic [TAG_W-1:0] victimSrc;
  logic [TAG_W-1:0] demotedTag;

  // parallel lookup in both lists
  for (genvar g = 0; g < ACT_N; g++) begin : g_actMatch
    assign actMatch[g] = (AIW'(g) < actCnt) && (actQ[g] == reqTag);
  end

  for (genvar g = 0; g < SC_D; g++) begin : g_scMatch
    assign scMatch[g] = (SC_N > 0) && (SIW'(g) < scCnt) && (scQ[g] == reqTag);
  end

  always_comb begin
    scHitIdx = '0;
    for (int i = 0; i < SC_D; i++) begin
      if (scMatch[i]) scHitIdx = SXW'(i);
    end
  end

  assign actHit     = |actMatch;
  assign scHit      = |scMatch;
  assign actFull    = (actCnt == AIW'(ACT_N));
  assign scFull     = (SC_N == 0) || (scCnt == SIW'(SC_D));
  assign demotedTag = actQ[ACT_N-1];
  assign remIdx     = ops.scRemTail ? SXW'(SC_D - 1) : scHitIdx;

  // victim source: standby tail, or direct tail when there is no standby list
  if (SC_N > 0) begin : g_vicStandby
    assign victimSrc = scQ[SC_D-1];
  end else begin : g_vicDirect
    assign victimSrc = actQ[ACT_N-1];
  end

  // direct list next state: shift towards the tail on insertion
  always_comb begin
    actN    = actQ;
    actCntN = actCnt;
    if (ops.actInsert) begin
      for (int i = 1; i < ACT_N; i++) actN[i] = actQ[i-1];
      actN[0] = reqTag;
      if (!ops.demote) actCntN = actCnt + AIW'(1);
    end
  end

  // standby list next state: removal first, then push at head
  always_comb begin
    scRem  = scQ;
    scCntN = scCnt;
    if (ops.scRemove) begin
      for (int i = 0; i < SC_D - 1; i++) begin
        if (SXW'(i) >= remIdx) scRem[i] = scQ[i+1];
      end
      scCntN = scCntN - SIW'(1);
    end
    scN = scRem;
    if (ops.scPush) begin
      for (int i = 1; i < SC_D; i++) scN[i] = scRem[i-1];
      scN[0] = demotedTag;
      scCntN = scCntN + SIW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ACT_N; i++) actQ[i] <= '0;
      for (int i = 0; i < SC_D; i++)  scQ[i]  <= '0;
      actCnt    <= '0;
      scCnt     <= '0;
      victimTag <= '0;
    end else begin
      actQ   <= actN;
      scQ    <= scN;
      actCnt <= actCntN;
      scCnt  <= scCntN;
      if (ops.evict) victimTag <= victimSrc;
    end
  end

endmodule

// File: rtl/scl_ctrl.sv
module scl_ctrl
  import scl_pkg::*;
#(
  parameter int SC_N = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       actHit,
  input  logic       scHit,
  input  logic       actFull,
  input  logic       scFull,
  output list_ops_t  ops,
  output logic       rspValid,
  output rsp_code_e  rspCode,
  output logic       victimValid
);

  logic fault, rescue, demote, evict;
  rsp_code_e codeNext;

  assign fault  = reqValid && !actHit;
  assign rescue = fault && scHit;
  assign demote = fault && actFull;
  assign evict  = fault && !scHit && actFull && scFull;

  always_comb begin
    ops.actInsert = fault;
    ops.demote    = demote;
    ops.scRemove  = rescue || (evict && (SC_N > 0));
    ops.scRemTail = !rescue;
    ops.scPush    = demote && (SC_N > 0);
    ops.evict     = evict;
  end

  always_comb begin
    if (!fault)      codeNext = RSP_HIT;
    else if (rescue) codeNext = RSP_RESCUE;
    else if (evict)  codeNext = RSP_EVICT;
    else             codeNext = RSP_FILL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspCode     <= RSP_HIT;
      victimValid <= 1'b0;
    end else begin
      rspValid    <= reqValid;
      rspCode     <= codeNext;
      victimValid <= evict;
    end
  end

endmodule

// File: rtl/scl_page_mgr.sv
module scl_page_mgr
  import scl_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int ACT_N = 3,
  parameter int SC_N  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [TAG_W-1:0] reqTag,
  output logic             rspValid,
  output logic [1:0]       rspCode,
  output logic             victimValid,
  output logic [TAG_W-1:0] victimTag
);

  localparam int SC_D = (SC_N > 0) ? SC_N : 1;
  localparam int AIW  = $clog2(ACT_N + 1);
  localparam int SIW  = $clog2(SC_D + 1);

  list_ops_t      ops;
  rsp_code_e      codeQ;
  logic           actHit, scHit, actFull, scFull;
  logic [AIW-1:0] actCnt;
  logic [SIW-1:0] scCnt;

  scl_lists #(.TAG_W(TAG_W), .ACT_N(ACT_N), .SC_N(SC_N)) u_lists (
    .clk      (clk),
    .rstN     (rstN),
    .reqTag   (reqTag),
    .ops      (ops),
    .actHit   (actHit),
    .scHit    (scHit),
    .actFull  (actFull),
    .scFull   (scFull),
    .actCnt   (actCnt),
    .scCnt    (scCnt),
    .victimTag(victimTag)
  );

  scl_ctrl #(.SC_N(SC_N)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .actHit     (actHit),
    .scHit      (scHit),
    .actFull    (actFull),
    .scFull     (scFull),
    .ops        (ops),
    .rspValid   (rspValid),
    .rspCode    (codeQ),
    .victimValid(victimValid)
  );

  assign rspCode = codeQ;

endmodule

// File: rtl/scl_page_mgr_chk.sv
module scl_page_mgr_chk #(
  parameter int ACT_N = 3,
  parameter int SC_N  = 2,
  localparam int SC_D = (SC_N > 0) ? SC_N : 1,
  localparam int AIW  = $clog2(ACT_N + 1),
  localparam int SIW  = $clog2(SC_D + 1)
) (
  input logic           clk,
  input logic           rstN,
  input logic           reqValid,
  input logic           rspValid,
  input logic [1:0]     rspCode,
  input logic           victimValid,
  input logic [AIW-1:0] actCnt,
  input logic [SIW-1:0] scCnt
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R11
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R9
  victim_only_evict_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> (rspValid && rspCode == 2'd3));

  // R7
  evict_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && actCnt != AIW'(ACT_N)) |=> !victimValid);

  // R8
  no_evict_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && SC_N > 0 && scCnt != SIW'(SC_D)) |=> !victimValid);

  // R3
  hit_keeps_lists_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == 2'd0) |-> ($stable(actCnt) && $stable(scCnt)));

  // R5
  standby_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (scCnt != '0) |-> (actCnt == AIW'(ACT_N)));

endmodule

bind scl_page_mgr scl_page_mgr_chk #(.ACT_N(ACT_N), .SC_N(SC_N)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .rspValid   (rspValid),
  .rspCode    (rspCode),
  .victimValid(victimValid),
  .actCnt     (actCnt),
  .scCnt      (scCnt)
);

// File: tb/scl_page_mgr_bench.sv
`timescale 1ns/1ps
module scl_page_mgr_bench;

  localparam int TAG_W = 4;
  localparam int ACT_N = 3;
  localparam int SC_N  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [TAG_W-1:0] reqTag = '0;
  logic rspValid, victimValid;
  logic [1:0] rspCode;
  logic [TAG_W-1:0] victimTag;

  logic fReqValid = 1'b0;
  logic [TAG_W-1:0] fReqTag = '0;
  logic fRspValid, fVictimValid;
  logic [1:0] fRspCode;
  logic [TAG_W-1:0] fVictimTag;

  int nChecks = 0;
  int nErrors = 0;
  int mAct[$];
  int mSc[$];

  always #2.5 clk = ~clk;

  scl_page_mgr #(.TAG_W(TAG_W), .ACT_N(ACT_N), .SC_N(SC_N)) u_scl_page_mgr (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTag(reqTag),
    .rspValid(rspValid), .rspCode(rspCode),
    .victimValid(victimValid), .victimTag(victimTag)
  );

  scl_page_mgr #(.TAG_W(TAG_W), .ACT_N(ACT_N), .SC_N(0)) u_scl_page_mgr_fifo (
    .clk(clk), .rstN(rstN), .reqValid(fReqValid), .reqTag(fReqTag),
    .rspValid(fRspValid), .rspCode(fRspCode),
    .victimValid(fVictimValid), .victimTag(fVictimTag)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // queue model of the two lists; index 0 is the head
  task automatic mStep(input int tag, output int code, output int vic, output string rq);
    int k;
    int d;
    vic = -1;
    k = -1;
    foreach (mAct[i]) if (mAct[i] == tag) k = i;
    if (k >= 0) begin
      code = 0; rq = "R3";
      return;
    end
    foreach (mSc[i]) if (mSc[i] == tag) k = i;
    if (k >= 0) begin
      mSc.delete(k);
      if (mAct.size() == ACT_N) begin
        d = mAct.pop_back();
        mSc.push_front(d);
      end
      mAct.push_front(tag);
      code = 1; rq = "R6";
      return;
    end
    if (mAct.size() < ACT_N) begin
      mAct.push_front(tag);
      code = 2; rq = "R4";
      return;
    end
    d = mAct.pop_back();
    if (mSc.size() == SC_N) begin
      vic = mSc.pop_back();
      code = 3; rq = "R7";
    end else begin
      code = 2; rq = "R8";
    end
    mSc.push_front(d);
    mAct.push_front(tag);
  endtask

  // drive at a falling edge, read the result one falling edge later
  task automatic doReq(input int tag, input string extra);
    int code, vic;
    string rq;
    mStep(tag, code, vic, rq);
    reqValid = 1'b1;
    reqTag   = TAG_W'(tag);
    @(negedge clk);
    reqValid = 1'b0;
    chk(rspValid == 1'b1, "R2 rspValid", int'(rspValid), 1);
    chk(int'(rspCode) == code, {rq, " ", extra, " rspCode"}, int'(rspCode), code);
    chk(victimValid == (code == 3), "R9 victimValid", int'(victimValid), int'(code == 3));
    if (code == 3) chk(int'(victimTag) == vic, "R7 victimTag", int'(victimTag), vic);
  endtask

  task automatic doIdle();
    reqValid = 1'b0;
    @(negedge clk);
    chk(rspValid == 1'b0, "R11 idle rspValid", int'(rspValid), 0);
    chk(victimValid == 1'b0, "R11 idle victimValid", int'(victimValid), 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    reqValid = 1'b0;
    fReqValid = 1'b0;
    repeat (3) @(negedge clk);
    chk(rspValid == 1'b0, "R1 rspValid in reset", int'(rspValid), 0);
    chk(victimValid == 1'b0, "R1 victimValid in reset", int'(victimValid), 0);
    rstN = 1'b1;
    mAct.delete();
    mSc.delete();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL R2 watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int fTags[11] = '{1, 2, 3, 1, 2, 4, 1, 4, 2, 3, 2};
    int fCode[11] = '{2, 2, 2, 0, 0, 3, 3, 0, 3, 3, 0};
    int fVic[11]  = '{0, 0, 0, 0, 0, 1, 2, 0, 3, 4, 0};
    int seedVal;
    seedVal = $urandom(32'd20240611);

    @(negedge clk);
    doReset();

    // R10: plain FIFO when the standby list has no room
    for (int i = 0; i < 11; i++) begin
      fReqValid = 1'b1;
      fReqTag   = TAG_W'(fTags[i]);
      @(negedge clk);
      fReqValid = 1'b0;
      chk(int'(fRspCode) == fCode[i], "R10 fifo rspCode", int'(fRspCode), fCode[i]);
      chk(fVictimValid == (fCode[i] == 3), "R10 fifo victimValid",
          int'(fVictimValid), int'(fCode[i] == 3));
      if (fCode[i] == 3)
        chk(int'(fVictimTag) == fVic[i], "R10 fifo victimTag", int'(fVictimTag), fVic[i]);
    end

    // directed walk through every transition
    doReq(1, "R1 first");
    doReq(2, "fill");
    doReq(3, "fill");
    doReq(1, "hit");
    doIdle();
    doReq(4, "R5 demote");
    doReq(1, "R5 rescue of demoted");
    doReq(5, "standby fills");
    doReq(6, "both full");
    doReq(3, "rescue");
    doReq(7, "evict lru");
    doReq(1, "hit after moves");
    doIdle();
    doReq(2, "after idle");

    // random traffic over a small tag range
    for (int n = 0; n < 600; n++) begin
      if (($urandom() % 8) == 0) doIdle();
      else doReq(int'($urandom() % 8), "random");
    end

    // reset mid-run: lists are emptied again
    doReset();
    doReq(1, "R1 after reset");
    doReq(1, "R1 hit after reset");

    summary();
    $finish;
  end

endmodule